// File: doc/BRIEF.md
# Byte-Framed Bus Bridge

The bridge sits between a byte-wide receive FIFO (as presented by a USB byte interface) and an internal memory-mapped bus with a 16-bit address and 8-bit data. A host encodes each bus access as four bytes. Every byte carries its own slot number in its two top bits, so the bridge can spot a lost, extra or reordered byte without a separate framing signal. The bridge rebuilds a read/not-write flag, a 15-bit address and an 8-bit data value. After the fourth byte it runs one bus cycle, and for a read it returns the fetched byte as a single reply byte on a transmit stream.

The byte layout is fixed. Byte `0` is `{00, rnw, A14..A10}`. Byte `1` is `{01, A9..A4}`. Byte `2` is `{10, A3..A0, D7, D6}`. Byte `3` is `{11, D5..D0}`.

The frame assembler has four states, one for each expected slot: `A_SLOT0`, `A_SLOT1`, `A_SLOT2` and `A_SLOT3`.
- A tag-00 byte always moves the assembler to `A_SLOT1`.
- A byte whose tag matches the expected slot advances `A_SLOT1`→`A_SLOT2`→`A_SLOT3`.
- At `A_SLOT3`, a tag-11 byte completes the frame and returns the assembler to `A_SLOT0`.
- Any other byte leaves the state unchanged and is dropped.

The bus sequencer has three states: `SQ_IDLE`, `SQ_BUS` and `SQ_REPLY`.
- A completed frame moves it `SQ_IDLE`→`SQ_BUS`.
- In `SQ_BUS`, the acknowledge moves it to `SQ_REPLY` for a read or to `SQ_IDLE` for a write.
- In `SQ_REPLY`, the transmit handshake moves it back to `SQ_IDLE`.

Top module: `byte_bus_bridge`

## Requirements
- R1: Bytes are decoded by tag: tag `00` carries rnw in bit 5 and A14..A10 in bits 4..0; tag `01` carries A9..A4; tag `10` carries A3..A0 in bits 5..2 and D7..D6 in bits 1..0; tag `11` carries D5..D0.
- R2: `bus_addr` equals the assembled 15-bit address with bit 15 always 0.
- R3: A write frame (rnw=0) produces one bus cycle with `bus_we`=1 and `bus_wdata` equal to the assembled data, and no reply byte.
- R4: A read frame (rnw=1) produces one bus cycle with `bus_we`=0 and `bus_wdata`=0, and then exactly one reply byte equal to `bus_rdata` sampled at the acknowledge; `tx_data` is held while `tx_valid` waits for `tx_ready`.
- R5: A tag-00 byte restarts assembly from any state, and a partial frame is dropped without a bus cycle.
- R6: A byte whose tag is neither 00 nor the expected slot is discarded and leaves the assembly state intact. It sets `frame_err`, which stays 1 until reset.
- R7: `rx_ready` is 0 from the cycle after byte 3 is accepted until the bus cycle and any reply have completed. `bus_req` and `bus_addr` hold until `bus_ack`.
- R8: `bus_vram_sel` is 1 during a bus cycle exactly when `bus_addr` is below 1000.
- R9: After reset, `rx_ready`=1, `bus_req`=0, `tx_valid`=0 and `frame_err`=0.
- R10: A bus cycle starts only after a complete, correctly tagged four-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Bridge accepts a byte this cycle |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Bus address, bit 15 always 0 |
| bus_wdata | output | 8 | Write data (0 for reads) |
| bus_vram_sel | output | 1 | Address lies in voxel memory (< 1000) |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Bus cycle completion |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Reply byte taken |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Byte 3 is accepted at edge k. `rx_ready` falls in the cycle after edge k, and `bus_req` rises after edge k+1. After the edge where `bus_ack` is seen, `bus_req` drops, and for a read `tx_valid` rises in that same cycle. The bench drives and samples only on falling edges, so each result is read half a cycle after the rising edge that produced it. A combined bus-model and monitor compares each bus cycle at the point where it raises the acknowledge, and each reply at the point where it raises `tx_ready`, against queues that the driver filled from the requirements. Framing-error and ready checks are taken at the falling edge that follows the accepting edge.

// File: rtl/bbb_pkg.sv
package bbb_pkg;
    localparam int BYTE_W  = 8;
    localparam int TAG_W   = 2;
    localparam int PAY_W   = BYTE_W - TAG_W;
    localparam int FADDR_W = 15;
    localparam int BADDR_W = FADDR_W + 1;

    typedef struct packed {
        logic               rnw;
        logic [FADDR_W-1:0] addr;
        logic [BYTE_W-1:0]  data;
    } frame_t;

    typedef enum logic [1:0] {
        A_SLOT0 = 2'd0,
        A_SLOT1 = 2'd1,
        A_SLOT2 = 2'd2,
        A_SLOT3 = 2'd3
    } asm_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BUS,
        SQ_REPLY
    } seq_state_t;
endpackage

// File: rtl/bbb_frame_asm.sv
module bbb_frame_asm
    import bbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_ready,
    output logic              frm_valid,
    output frame_t            frm,
    output logic              frame_err
);
    asm_state_t st, st_nxt;
    logic [TAG_W-1:0] tag;
    logic [PAY_W-1:0] pay;
    logic accept, ld0, ld1, ld2, fire, bad;

    logic       rnw_q;
    logic [4:0] a_hi_q;
    logic [5:0] a_mid_q;
    logic [3:0] a_lo_q;
    logic [1:0] d_hi_q;
    logic [5:0] d_lo_q;

    assign tag    = rx_data[BYTE_W-1 -: TAG_W];
    assign pay    = rx_data[PAY_W-1:0];
    assign accept = rx_valid && rx_ready;

    always_comb begin
        st_nxt = st;
        ld0 = 1'b0; ld1 = 1'b0; ld2 = 1'b0; fire = 1'b0; bad = 1'b0;
        if (accept) begin
            if (tag == 2'd0) begin
                ld0    = 1'b1;
                st_nxt = A_SLOT1;
            end else if (tag == 2'(st)) begin
                unique case (st)
                    A_SLOT1: begin ld1 = 1'b1; st_nxt = A_SLOT2; end
                    A_SLOT2: begin ld2 = 1'b1; st_nxt = A_SLOT3; end
                    A_SLOT3: begin fire = 1'b1; st_nxt = A_SLOT0; end
                    A_SLOT0: st_nxt = A_SLOT1;
                endcase
            end else begin
                bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= A_SLOT0;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_valid <= 1'b0;
            frame_err <= 1'b0;
            rnw_q   <= 1'b0;
            a_hi_q  <= '0;
            a_mid_q <= '0;
            a_lo_q  <= '0;
            d_hi_q  <= '0;
            d_lo_q  <= '0;
        end else begin
            frm_valid <= fire;
            if (bad) frame_err <= 1'b1;
            if (ld0) begin
                rnw_q  <= pay[5];
                a_hi_q <= pay[4:0];
            end
            if (ld1) a_mid_q <= pay;
            if (ld2) begin
                a_lo_q <= pay[5:2];
                d_hi_q <= pay[1:0];
            end
            if (fire) d_lo_q <= pay;
        end
    end

    assign frm.rnw  = rnw_q;
    assign frm.addr = {a_hi_q, a_mid_q, a_lo_q};
    assign frm.data = {d_hi_q, d_lo_q};

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err); // R6
    AST_FRAME_AFTER_TAG3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> $past(accept && tag == 2'd3)); // R10
endmodule

// File: rtl/bbb_bus_seq.sv
module bbb_bus_seq
    import bbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    input  frame_t             frm,
    input  logic               bus_ack,
    input  logic [BYTE_W-1:0]  bus_rdata,
    input  logic               tx_ready,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0]  bus_wdata,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_data,
    output logic               idle
);
    seq_state_t st, st_nxt;
    logic               rnw_q;
    logic [BADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0]  wdata_q, rdat_q;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SQ_IDLE:  if (frm_valid) st_nxt = SQ_BUS;
            SQ_BUS:   if (bus_ack) st_nxt = rnw_q ? SQ_REPLY : SQ_IDLE;
            SQ_REPLY: if (tx_ready) st_nxt = SQ_IDLE;
            default:  st_nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnw_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdat_q  <= '0;
        end else begin
            if (st == SQ_IDLE && frm_valid) begin
                rnw_q   <= frm.rnw;
                addr_q  <= {1'b0, frm.addr};
                wdata_q <= frm.rnw ? '0 : frm.data;
            end
            if (st == SQ_BUS && bus_ack && rnw_q) rdat_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_req   = (st == SQ_BUS);
        tx_valid  = (st == SQ_REPLY);
        idle      = (st == SQ_IDLE);
        bus_we    = !rnw_q;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        tx_data   = rdat_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr)); // R7
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req); // R10
endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
    import bbb_pkg::*;
#(
    parameter int VRAM_DEPTH = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          rx_data,
    input  logic                rx_valid,
    output logic                rx_ready,
    output logic                bus_req,
    output logic                bus_we,
    output logic [15:0]         bus_addr,
    output logic [7:0]          bus_wdata,
    output logic                bus_vram_sel,
    input  logic [7:0]          bus_rdata,
    input  logic                bus_ack,
    output logic [7:0]          tx_data,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic                frame_err
);
    logic   frm_valid;
    frame_t frm;
    logic   seq_idle;

    assign rx_ready = seq_idle && !frm_valid;

    bbb_frame_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .frm_valid (frm_valid),
        .frm       (frm),
        .frame_err (frame_err)
    );

    bbb_bus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm       (frm),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .tx_ready  (tx_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .idle      (seq_idle)
    );

    assign bus_vram_sel = (32'(bus_addr) < VRAM_DEPTH);

    AST_BUSY_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || tx_valid || frm_valid) |-> !rx_ready); // R7
    AST_FRAME_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> bus_req); // R10
    AST_ADDR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !bus_addr[15]); // R2
endmodule

// File: tb/test_byte_bus_bridge.sv
module test_byte_bus_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic       bus_req, bus_we, bus_vram_sel;
    logic [15:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = '0;
    logic       bus_ack = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       frame_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        vram;
    } bus_item_t;

    bus_item_t  exp_bus[$];
    logic [7:0] exp_rep[$];

    always #4 clk = ~clk;

    byte_bus_bridge i_byte_bus_bridge (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_vram_sel(bus_vram_sel),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .frame_err(frame_err)
    );

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] + 8'h3C ^ a[14:8];
    endfunction

    function automatic logic [7:0] mk_byte(input logic rnw, input logic [14:0] a,
                                           input logic [7:0] d, input int idx);
        case (idx)
            0: return {2'b00, rnw, a[14:10]};
            1: return {2'b01, a[9:4]};
            2: return {2'b10, a[3:0], d[7:6]};
            default: return {2'b11, d[5:0]};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // R1 R3 R4: push the expected bus item (and reply) then send the four bytes
    task automatic send_txn(input logic rnw, input logic [14:0] a, input logic [7:0] d);
        bus_item_t it;
        it.we    = !rnw;
        it.addr  = {1'b0, a};
        it.wdata = rnw ? 8'h00 : d;
        it.vram  = (a < 15'd1000);
        exp_bus.push_back(it);
        if (rnw) exp_rep.push_back(mem_model({1'b0, a}));
        for (int i = 0; i < 4; i++) send_byte(mk_byte(rnw, a, d, i));
        check(rx_ready == 1'b0, "R7", "rx_ready after byte 3", rx_ready, 0);
    endtask

    // bus model and bus monitor
    int lat = 0;
    int lat_sel = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !bus_ack) begin
                if (lat == 0) begin
                    if (exp_bus.size() == 0) begin
                        check(1'b0, "R10", "unexpected bus cycle", bus_addr, 0);
                    end else begin
                        bus_item_t e;
                        e = exp_bus.pop_front();
                        check(bus_addr == e.addr, "R2", "bus_addr", bus_addr, e.addr);
                        check(bus_we == e.we, "R3", "bus_we", bus_we, e.we);
                        check(bus_wdata == e.wdata, e.we ? "R3" : "R4", "bus_wdata",
                              bus_wdata, e.wdata);
                        check(bus_vram_sel == e.vram, "R8", "bus_vram_sel",
                              bus_vram_sel, e.vram);
                    end
                    bus_rdata = mem_model(bus_addr);
                    bus_ack   = 1'b1;
                    lat_sel   = (lat_sel + 1) % 3;
                    lat       = lat_sel;
                end else begin
                    lat--;
                end
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    // reply monitor with backpressure
    int rdy_wait = 2;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                if (rdy_wait == 0) begin
                    if (exp_rep.size() == 0) begin
                        check(1'b0, "R3", "unexpected reply", tx_data, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_rep.pop_front();
                        check(tx_data == e, "R4", "reply byte", tx_data, e);
                    end
                    tx_ready = 1'b1;
                    rdy_wait = 2;
                end else begin
                    rdy_wait--;
                    tx_ready = 1'b0;
                end
            end else begin
                tx_ready = 1'b0;
                rdy_wait = 2;
            end
        end
    end

    task automatic drain();
        int n = 0;
        while ((exp_bus.size() != 0 || exp_rep.size() != 0 || !rx_ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                check(1'b0, "WDOG", "watchdog expired", cycles, 20000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(rx_ready == 1'b1, "R9", "rx_ready", rx_ready, 1);
        check(bus_req == 1'b0, "R9", "bus_req", bus_req, 0);
        check(tx_valid == 1'b0, "R9", "tx_valid", tx_valid, 0);
        check(frame_err == 1'b0, "R9", "frame_err", frame_err, 0);

        // R1 R3 R8: writes at VRAM boundaries
        send_txn(1'b0, 15'd0, 8'hA5);
        send_txn(1'b0, 15'd999, 8'h3C);
        send_txn(1'b0, 15'd1000, 8'hC3);
        // R4: reads including top address
        send_txn(1'b1, 15'h7FFF, 8'hFF);
        send_txn(1'b1, 15'h1234, 8'h99);
        send_txn(1'b0, 15'h5555, 8'hFF);
        send_txn(1'b1, 15'd999, 8'h00);
        drain();
        check(frame_err == 1'b0, "R6", "no error on clean frames", frame_err, 0);

        // R5: partial frames dropped by a new tag-00 byte
        send_byte(mk_byte(1'b0, 15'h0111, 8'h11, 0));
        send_byte(mk_byte(1'b0, 15'h0111, 8'h11, 1));
        send_txn(1'b0, 15'h0222, 8'h22);
        send_byte(mk_byte(1'b1, 15'h0333, 8'h33, 0));
        send_byte(mk_byte(1'b1, 15'h0333, 8'h33, 1));
        send_byte(mk_byte(1'b1, 15'h0333, 8'h33, 2));
        send_txn(1'b1, 15'h0444, 8'h44);
        drain();
        check(frame_err == 1'b0, "R5", "restart is not an error", frame_err, 0);

        // R6: stray tag at slot 0 discarded, error set
        send_byte(mk_byte(1'b0, 15'h0, 8'h5A, 3));
        @(negedge clk);
        check(frame_err == 1'b1, "R6", "frame_err after stray byte", frame_err, 1);
        check(bus_req == 1'b0, "R10", "no bus cycle from stray byte", bus_req, 0);
        // R6: mismatched byte inside a frame keeps assembly state
        begin
            bus_item_t it;
            it.we = 1'b1; it.addr = 16'h0ABC; it.wdata = 8'h6D; it.vram = 1'b0;
            exp_bus.push_back(it);
            send_byte(mk_byte(1'b0, 15'h0ABC, 8'h6D, 0));
            send_byte(mk_byte(1'b0, 15'h0ABC, 8'h6D, 1));
            send_byte(mk_byte(1'b0, 15'h0ABC, 8'hFF, 3));
            @(negedge clk);
            check(bus_req == 1'b0, "R10", "no bus cycle on mistagged byte", bus_req, 0);
            send_byte(mk_byte(1'b0, 15'h0ABC, 8'h6D, 2));
            send_byte(mk_byte(1'b0, 15'h0ABC, 8'h6D, 3));
        end
        send_txn(1'b1, 15'h0010, 8'h00);
        drain();
        check(frame_err == 1'b1, "R6", "frame_err sticky", frame_err, 1);
        check(exp_bus.size() == 0, "R10", "all bus cycles seen", exp_bus.size(), 0);
        check(exp_rep.size() == 0, "R4", "all replies seen", exp_rep.size(), 0);
        check(rx_ready == 1'b1, "R7", "rx_ready back high", rx_ready, 1);
        finish_run();
    end
endmodule